// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Chain

This block compares two unsigned operands and reports whether the first is greater than, equal to or less than the second. It is built from identical 4-bit slices. Each slice compares its own bit pair group and merges that local verdict with a three-wire verdict (greater, equal, less) handed to it by the next less significant slice. The default build chains three slices into a 12-bit comparator. The slice width and the slice count are both parameters.

The chain is purely combinational. The least significant slice takes its cascade verdict from the top-level cascade inputs. Tie those inputs to greater=0, equal=1, less=0 for a standalone compare. Drive them from another chain's outputs to extend the width further.

A slice whose operand bits all match passes its incoming verdict through unchanged. Otherwise its own verdict replaces the incoming one. The more significant half therefore always decides when the two halves disagree.

Top module: `magCmpChain`

## Requirements
- R1: With cascade inputs greater=0, equal=1, less=0, `gtOut` is 1 exactly when the unsigned value of `xIn` exceeds that of `yIn`.
- R2: With cascade inputs greater=0, equal=1, less=0, `eqOut` is 1 exactly when `xIn` equals `yIn`. This includes the all-zero operands applied during bench reset.
- R3: With cascade inputs greater=0, equal=1, less=0, `ltOut` is 1 exactly when `xIn` is below `yIn`.
- R4: Whenever exactly one cascade input is 1, exactly one of `gtOut`, `eqOut`, `ltOut` is 1.
- R5: When `xIn` equals `yIn`, the outputs copy the cascade inputs: `gtOut` from `cascGtIn`, `eqOut` from `cascEqIn` and `ltOut` from `cascLtIn`.
- R6: When `xIn` differs from `yIn`, the cascade inputs have no effect on any output.
- R7: A difference in a more significant slice decides the result, whatever the less significant slices report. For example, X=0x100 and Y=0x0FF give greater.
- R8: A chain of one slice (NUM_SLICES=1) gives the correct greater, equal and less result for all 256 pairs of 4-bit operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xIn | input | SLICE_W*NUM_SLICES | First unsigned operand |
| yIn | input | SLICE_W*NUM_SLICES | Second unsigned operand |
| cascGtIn | input | 1 | Incoming "greater" verdict from a less significant stage |
| cascEqIn | input | 1 | Incoming "equal" verdict from a less significant stage |
| cascLtIn | input | 1 | Incoming "less" verdict from a less significant stage |
| gtOut | output | 1 | First operand is greater |
| eqOut | output | 1 | Operands equal (qualified by cascade) |
| ltOut | output | 1 | First operand is less |

## Verification
The assertions check on every input change that the outputs are one-hot for a one-hot cascade verdict. They also check that matching operands pass the cascade through, that differing operands ignore it, and that the outputs agree with an unsigned whole-width compare under the neutral cascade. Only the bench scenarios show the overall coverage: the full sweep of a single slice, random wide pairs, and pairs built so that the high and low slices disagree.

// File: rtl/cmpPkg.sv
package cmpPkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmpRes_t;
endpackage

// File: rtl/cmpSliceLocal.sv
module cmpSliceLocal
  import cmpPkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] xPart,
  input  logic [SLICE_W-1:0] yPart,
  output cmpRes_t            localRes
);
  logic [SLICE_W-1:0] bitSame;
  logic               gtBit;
  logic               ltBit;
  logic               found;

  assign bitSame = ~(xPart ^ yPart);

  always_comb begin
    gtBit = 1'b0;
    ltBit = 1'b0;
    found = 1'b0;
    for (int i = SLICE_W - 1; i >= 0; i--) begin
      if (!found && !bitSame[i]) begin
        gtBit = xPart[i];
        ltBit = yPart[i];
        found = 1'b1;
      end
    end
  end

  assign localRes.gt = gtBit;
  assign localRes.lt = ltBit;
  assign localRes.eq = &bitSame;
endmodule

// File: rtl/cmpSliceMerge.sv
module cmpSliceMerge
  import cmpPkg::*;
(
  input  cmpRes_t localRes,
  input  cmpRes_t cascIn,
  output cmpRes_t mergedOut
);
  always_comb begin
    if (localRes.eq) begin
      mergedOut = cascIn;
    end else begin
      mergedOut.gt = localRes.gt;
      mergedOut.eq = 1'b0;
      mergedOut.lt = localRes.lt;
    end
  end
endmodule

// File: rtl/magCmpChain.sv
module magCmpChain
  import cmpPkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3
) (
  input  logic [SLICE_W*NUM_SLICES-1:0] xIn,
  input  logic [SLICE_W*NUM_SLICES-1:0] yIn,
  input  logic                          cascGtIn,
  input  logic                          cascEqIn,
  input  logic                          cascLtIn,
  output logic                          gtOut,
  output logic                          eqOut,
  output logic                          ltOut
);
  localparam int TOTAL_W = SLICE_W * NUM_SLICES;

  cmpRes_t stageRes [NUM_SLICES+1];

  assign stageRes[0].gt = cascGtIn;
  assign stageRes[0].eq = cascEqIn;
  assign stageRes[0].lt = cascLtIn;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cmpRes_t localRes;
    cmpSliceLocal #(.SLICE_W(SLICE_W)) u_local (
      .xPart    (xIn[k*SLICE_W +: SLICE_W]),
      .yPart    (yIn[k*SLICE_W +: SLICE_W]),
      .localRes (localRes)
    );
    cmpSliceMerge u_merge (
      .localRes  (localRes),
      .cascIn    (stageRes[k]),
      .mergedOut (stageRes[k+1])
    );
  end

  assign gtOut = stageRes[NUM_SLICES].gt;
  assign eqOut = stageRes[NUM_SLICES].eq;
  assign ltOut = stageRes[NUM_SLICES].lt;

  if (TOTAL_W < 1) begin : g_badWidth
    $error("magCmpChain: total width must be positive");
  end
endmodule

// File: rtl/magCmpChainChk.sv
module magCmpChainChk #(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3
) (
  input logic [SLICE_W*NUM_SLICES-1:0] xIn,
  input logic [SLICE_W*NUM_SLICES-1:0] yIn,
  input logic                          cascGtIn,
  input logic                          cascEqIn,
  input logic                          cascLtIn,
  input logic                          gtOut,
  input logic                          eqOut,
  input logic                          ltOut
);
  logic cascOneHot;
  logic cascNeutral;

  assign cascOneHot  = ($countones({cascGtIn, cascEqIn, cascLtIn}) == 1);
  assign cascNeutral = !cascGtIn && cascEqIn && !cascLtIn;

  always_comb begin
    if (cascOneHot) begin
      assert_one_hot_R4: assert ($countones({gtOut, eqOut, ltOut}) == 1);
    end
    if (xIn == yIn) begin
      assert_pass_through_R5: assert ({gtOut, eqOut, ltOut} == {cascGtIn, cascEqIn, cascLtIn});
    end else begin
      assert_casc_ignored_R6: assert (!eqOut && (gtOut == (xIn > yIn)) && (ltOut == (xIn < yIn)));
    end
    if (cascNeutral) begin
      assert_greater_R1: assert (gtOut == (xIn > yIn));
      assert_equal_R2:   assert (eqOut == (xIn == yIn));
      assert_less_R3:    assert (ltOut == (xIn < yIn));
    end
  end
endmodule

bind magCmpChain magCmpChainChk #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chk (
  .xIn(xIn), .yIn(yIn),
  .cascGtIn(cascGtIn), .cascEqIn(cascEqIn), .cascLtIn(cascLtIn),
  .gtOut(gtOut), .eqOut(eqOut), .ltOut(ltOut)
);

// File: tb/test_magCmpChain.sv
module test_magCmpChain;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int W  = SW * NS;

  typedef struct {
    bit         wide;
    logic [2:0] exp;
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0]  xW, yW;
  logic [SW-1:0] xS, yS;
  logic gW, eW, lW, gS, eS, lS;
  logic cgW, ceW, clW, cgS, ceS, clS;

  magCmpChain #(.SLICE_W(SW), .NUM_SLICES(NS)) i_magCmpChain (
    .xIn(xW), .yIn(yW), .cascGtIn(cgW), .cascEqIn(ceW), .cascLtIn(clW),
    .gtOut(gW), .eqOut(eW), .ltOut(lW)
  );
  magCmpChain #(.SLICE_W(SW), .NUM_SLICES(1)) i_magCmpChain_slice (
    .xIn(xS), .yIn(yS), .cascGtIn(cgS), .cascEqIn(ceS), .cascLtIn(clS),
    .gtOut(gS), .eqOut(eS), .ltOut(lS)
  );

  item_t sbQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [2:0] refCmp(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] casc);
    if (a > b) return 3'b100;
    if (a < b) return 3'b001;
    return casc;
  endfunction

  task automatic driveWide(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] casc, string req);
    item_t it;
    @(negedge clk);
    xW = a; yW = b; {cgW, ceW, clW} = casc;
    it.wide = 1'b1; it.exp = refCmp(a, b, casc); it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic driveSlice(logic [SW-1:0] a, logic [SW-1:0] b, string req);
    item_t it;
    @(negedge clk);
    xS = a; yS = b; {cgS, ceS, clS} = 3'b010;
    it.wide = 1'b0;
    it.exp = refCmp(W'(a), W'(b), 3'b010);
    it.req = req;
    sbQ.push_back(it);
  endtask

  always @(posedge clk) begin
    if (sbQ.size() > 0) begin
      item_t it;
      logic [2:0] act;
      it = sbQ.pop_front();
      act = it.wide ? {gW, eW, lW} : {gS, eS, lS};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: x=%h y=%h actual=%b expected=%b", it.req,
                 it.wide ? xW : W'(xS), it.wide ? yW : W'(yS), act, it.exp);
      end
    end
  end

  initial begin
    xW = '0; yW = '0; {cgW, ceW, clW} = 3'b010;
    xS = '0; yS = '0; {cgS, ceS, clS} = 3'b010;

    // Reset-time check: all-zero operands with neutral cascade -> equal.
    driveWide('0, '0, 3'b010, "R2 reset");
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Directed greater, less, equal checks.
    driveWide(12'h801, 12'h800, 3'b010, "R1");
    driveWide(12'h000, 12'hFFF, 3'b010, "R3");
    driveWide(12'hA5C, 12'hA5C, 3'b010, "R2");

    // Equal operands copy the cascade inputs.
    driveWide(12'h3C3, 12'h3C3, 3'b100, "R5");
    driveWide(12'h3C3, 12'h3C3, 3'b001, "R5");
    driveWide(12'h3C3, 12'h3C3, 3'b000, "R5");

    // Differing operands ignore the cascade inputs.
    driveWide(12'h002, 12'h001, 3'b001, "R6");
    driveWide(12'h001, 12'h002, 3'b100, "R6");
    driveWide(12'h010, 12'h011, 3'b111, "R6");

    // A more significant slice overrides the lower ones.
    driveWide(12'h100, 12'h0FF, 3'b010, "R7");
    driveWide(12'h0FF, 12'h100, 3'b010, "R7");
    driveWide(12'h1F0, 12'h20F, 3'b001, "R7");

    // Exhaustive sweep of a single slice.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        driveSlice(SW'(a), SW'(b), "R8");
      end
    end

    // Random wide pairs with each one-hot cascade value.
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] a, b;
      logic [2:0] c;
      a = W'($urandom);
      b = (n % 4 == 0) ? a : W'($urandom);
      c = 3'b001 << ($urandom % 3);
      driveWide(a, b, c, (a == b) ? "R5" : "R4");
    end

    // Random wide pairs with the neutral cascade.
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = (n % 8 == 0) ? a : W'($urandom);
      driveWide(a, b, 3'b010, (a > b) ? "R1" : ((a < b) ? "R3" : "R2"));
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule